// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port Controller

This block handles one general-purpose I/O port of a small microcontroller. It has six pin positions, and position 3 is not implemented. Each pin has four register bits: a data latch, a direction bit, a pull-up enable and, on the three low pins only, an LCD-bias select. For every pin the block works out four values: the pad output enable, the pad output value, the pad pull-up request and the gated input value that is returned on reads.

A peripheral can take over a pin's drive through its own output enable. An ordinary read returns what the pin actually carries, which includes a peripheral's output. A read-modify-write read returns the latch, so that the bits software writes back do not pick up pin levels by accident.

When the chip enters a low-power standby with the pin-state control bit set, every pad is forced to high impedance and its pull-up is released. The internal inputs are also clamped low so that pins left floating cannot cause leakage.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the data, direction and pull-up registers read 0 and the LCD-select register reads 6'b000111. `rdata` is 0 and no pad is driven.
- R2: Address 0 selects the data latch, 1 the direction register, 2 the pull-up register and 3 the LCD-select register. A register is written at the clock edge where `wr_en` is high. `rdata` is loaded at the edge where `rd_en` is high and holds that value until the next read.
- R3: A pin with direction bit 1 and no peripheral enable drives its pad (`pad_oe`=1) with the data-latch value.
- R4: A write to the data register always updates the latch, even on input pins. An input pin does not drive that value. The stored value is visible on a read-modify-write read and on the pad once the direction bit is set.
- R5: An ordinary read of address 0 returns the latch for pins in port-output mode. For all other pins it returns the pin level after a two-flop synchronizer, so a level must be stable for two clocks before the read strobe.
- R6: A read of address 0 with `rd_rmw`=1 returns the data latch for every pin, whatever the direction, the peripheral enables or the pin levels.
- R7: When `per_oe` is 1 for a pin, the pin drives `per_out` whatever its direction bit. An ordinary read returns that pin level, while a read-modify-write read returns the latch.
- R8: While its LCD-select bit is 1, the input of pins 0 to 2 is blocked and reads 0. The input works after the bit is cleared. Pins 4 and 5 have input enabled from reset. LCD-select bits 3 to 5 do not exist and read 0.
- R9: With `standby`=1 and `hiz_sel`=1, every pad has `pad_oe`=0 and `pad_pu`=0, and every input reads 0.
- R10: With `standby`=1 and `hiz_sel`=0, the pad drive is the same as outside standby.
- R11: `pad_pu` follows the pull-up bit, except that it is 0 while the pin actively drives a low level.
- R12: Pin position 3 reads 0 in every register, never drives or pulls up, and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| rd_en | input | 1 | One-cycle register read strobe |
| rd_rmw | input | 1 | Read is the read phase of a read-modify-write |
| addr | input | 2 | Register select |
| wdata | input | 6 | Write data |
| rdata | output | 6 | Read data, valid the cycle after `rd_en` |
| per_oe | input | 6 | Peripheral output enable per pin |
| per_out | input | 6 | Peripheral output value per pin |
| standby | input | 1 | Stop or watch mode active |
| hiz_sel | input | 1 | Pin-state control: force high-Z during standby |
| pad_in | input | 6 | Pin levels from the pads |
| pad_oe | output | 6 | Pad output enable |
| pad_out | output | 6 | Pad output value |
| pad_pu | output | 6 | Pad pull-up request |

## Verification
The bench writes data to input pins and checks that the latch holds the value while nothing is driven. A design that wrote the latch only for output pins would later drive a stale value once the direction changes. The same pin is then read in both ordinary and read-modify-write form with the pin level set opposite to the latch; a design that mixed the two paths would return the wrong source. Pins 0 to 2 are read before and after their LCD-select bits are cleared, and a design with the wrong reset mask would leak pin levels or block pins 4 and 5. Standby is checked with the pin-state control bit both set and clear, along with pull-up release on a low drive and the missing pin 3, so that a design that still drives, pulls up or passes input data in those states is caught.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_PULL = 2'd2,
    REG_LCD  = 2'd3
  } gpio_reg_e;

  // pull-up is released while the pad actively drives low
  function automatic logic pull_active(logic pu_bit, logic oe, logic val);
    return pu_bit & ~(oe & ~val);
  endfunction

  // read source: latch for rmw or port-output pins, synchronized pin otherwise
  function automatic logic read_src(logic rmw, logic port_out, logic latch, logic pin);
    return (rmw | port_out) ? latch : pin;
  endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int          W        = 6,
  parameter logic [W-1:0] IMPL    = 6'b110111,
  parameter logic [W-1:0] LCD_BITS = 6'b000111
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] pull_q,
  output logic [W-1:0] lcd_q
);

  // named write events
  logic data_wr, dir_wr, pull_wr, lcd_wr;
  assign data_wr = wr_en && (gpio_reg_e'(addr) == REG_DATA);
  assign dir_wr  = wr_en && (gpio_reg_e'(addr) == REG_DIR);
  assign pull_wr = wr_en && (gpio_reg_e'(addr) == REG_PULL);
  assign lcd_wr  = wr_en && (gpio_reg_e'(addr) == REG_LCD);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q[i] <= 1'b0;
          dir_q[i]  <= 1'b0;
          pull_q[i] <= 1'b0;
        end else begin
          if (data_wr) data_q[i] <= wdata[i];
          if (dir_wr)  dir_q[i]  <= wdata[i];
          if (pull_wr) pull_q[i] <= wdata[i];
        end
      end
    end else begin : g_none
      assign data_q[i] = 1'b0;
      assign dir_q[i]  = 1'b0;
      assign pull_q[i] = 1'b0;
    end

    if (IMPL[i] && LCD_BITS[i]) begin : g_lcd
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lcd_q[i] <= 1'b1;
        else if (lcd_wr) lcd_q[i] <= wdata[i];
      end
    end else begin : g_nolcd
      assign lcd_q[i] = 1'b0;
    end
  end

  AST_DIR_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> dir_q == ($past(wdata) & IMPL)); // R2

  AST_DATA_WRITE_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> data_q == ($past(wdata) & IMPL)); // R4

endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_port_pkg::*;
#(
  parameter int           W    = 6,
  parameter logic [W-1:0] IMPL = 6'b110111
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] pull_q,
  input  logic [W-1:0] per_oe,
  input  logic [W-1:0] per_out,
  input  logic         force_hiz,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] port_out
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (IMPL[i]) begin : g_impl
      logic drive;
      // priority: standby high-Z, then peripheral, then direction register
      assign drive       = ~force_hiz & (per_oe[i] | dir_q[i]);
      assign port_out[i] = dir_q[i] & ~per_oe[i];
      assign pad_oe[i]   = drive;
      assign pad_out[i]  = per_oe[i] ? per_out[i] : data_q[i];
      assign pad_pu[i]   = ~force_hiz & pull_active(pull_q[i], drive, pad_out[i]);
    end else begin : g_none
      assign port_out[i] = 1'b0;
      assign pad_oe[i]   = 1'b0;
      assign pad_out[i]  = 1'b0;
      assign pad_pu[i]   = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] in_en,
  output logic [W-1:0] sync_q
);

  logic [STAGES-1:0][W-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chain[s] <= '0;
      else if (s == 0) chain[s] <= pad_in & in_en;
      else             chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_q = chain[STAGES-1];

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int           W        = 6,
  parameter int           STAGES   = 2,
  parameter logic [W-1:0] IMPL     = 6'b110111,
  parameter logic [W-1:0] LCD_BITS = 6'b000111
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic         rd_rmw,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] per_oe,
  input  logic [W-1:0] per_out,
  input  logic         standby,
  input  logic         hiz_sel,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);

  logic [W-1:0] data_q, dir_q, pull_q, lcd_q;
  logic [W-1:0] port_out, sync_q, in_en, pin_view;
  logic         force_hiz;
  logic [W-1:0] rd_next;

  assign force_hiz = standby & hiz_sel;
  assign in_en     = IMPL & ~lcd_q & {W{~force_hiz}};

  gpio_regs #(.W(W), .IMPL(IMPL), .LCD_BITS(LCD_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q), .lcd_q(lcd_q)
  );

  gpio_pinmux #(.W(W), .IMPL(IMPL)) u_mux (
    .dir_q(dir_q), .data_q(data_q), .pull_q(pull_q),
    .per_oe(per_oe), .per_out(per_out), .force_hiz(force_hiz),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .port_out(port_out)
  );

  gpio_insync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .in_en(in_en), .sync_q(sync_q)
  );

  always_comb begin
    for (int i = 0; i < W; i++)
      pin_view[i] = read_src(rd_rmw, port_out[i], data_q[i], sync_q[i]);
  end

  always_comb begin
    unique case (gpio_reg_e'(addr))
      REG_DATA: rd_next = pin_view & IMPL;
      REG_DIR:  rd_next = dir_q;
      REG_PULL: rd_next = pull_q;
      REG_LCD:  rd_next = lcd_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  AST_HIZ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && hiz_sel) |-> (pad_oe == '0 && pad_pu == '0)); // R9

  AST_PU_OFF_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe & ~pad_out) == '0); // R11

  AST_RMW_RETURNS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_rmw && addr == 2'd0) |=> rdata == $past(data_q)); // R6

  AST_UNIMPL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata | pad_oe | pad_pu) & ~IMPL) == '0); // R12

  AST_PERIPH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !force_hiz |-> ((pad_oe & per_oe) == (per_oe & IMPL)
                    && (pad_out & per_oe) == (per_out & per_oe & IMPL))); // R7

endmodule

// File: tb/tb_gpio_port_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, rd_rmw = 1'b0;
  logic [1:0] addr = '0;
  logic [5:0] wdata = '0;
  logic [5:0] rdata;
  logic [5:0] per_oe = '0, per_out = '0;
  logic       standby = 1'b0, hiz_sel = 1'b0;
  logic [5:0] ext_in = '0;
  logic [5:0] pad_in, pad_oe, pad_out, pad_pu;

  int checks = 0;
  int fails  = 0;
  logic [5:0] rv;

  always #5 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_in);

  gpio_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_rmw(rd_rmw),
    .addr(addr), .wdata(wdata), .rdata(rdata), .per_oe(per_oe), .per_out(per_out),
    .standby(standby), .hiz_sel(hiz_sel), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic rmw, output logic [5:0] d);
    @(negedge clk); rd_en = 1'b1; rd_rmw = rmw; addr = a;
    @(negedge clk); rd_en = 1'b0; rd_rmw = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 rdata after reset", rdata, 6'b0);
    check("R1 pad_oe after reset", pad_oe, 6'b0);
    rd(2'd0, 1'b1, rv); check("R1 data latch", rv, 6'b0);
    rd(2'd1, 1'b0, rv); check("R1 dir", rv, 6'b0);
    rd(2'd2, 1'b0, rv); check("R1 pull", rv, 6'b0);
    rd(2'd3, 1'b0, rv); check("R1 lcd select", rv, 6'b000111);
  endtask

  task automatic t_output();
    wr(2'd1, 6'h3F);
    rd(2'd1, 1'b0, rv); check("R12 dir bit3 ignored", rv, 6'b110111);
    wr(2'd0, 6'b101010);
    check("R3 pad_oe", pad_oe, 6'b110111);
    check("R3 pad_out", pad_out & pad_oe, 6'b100010);
    rd(2'd0, 1'b0, rv); check("R5 output pins read latch", rv, 6'b100010);
    rd(2'd2, 1'b0, rv); check("R2 read holds until next read", rdata, rv);
  endtask

  task automatic t_input();
    wr(2'd1, 6'h00);
    wr(2'd0, 6'b010101);
    check("R4 input pins not driven", pad_oe, 6'b0);
    ext_in = 6'b110011; settle();
    rd(2'd0, 1'b0, rv); check("R8 lcd pins blocked, R5 pins 4-5 read", rv, 6'b110000);
    rd(2'd0, 1'b1, rv); check("R6 rmw reads latch", rv, 6'b010101);
    wr(2'd3, 6'h00);
    rd(2'd3, 1'b0, rv); check("R8 lcd cleared", rv, 6'b0);
    ext_in = 6'b000101; settle();
    rd(2'd0, 1'b0, rv); check("R8 low pins read after clear", rv, 6'b000101);
    ext_in = 6'b001010; settle();
    rd(2'd0, 1'b0, rv); check("R5 pin level not latch", rv, 6'b000010);
    wr(2'd1, 6'h3F);
    check("R4 latch appears when output", pad_out & pad_oe, 6'b010101);
    wr(2'd3, 6'h3F);
    rd(2'd3, 1'b0, rv); check("R8 only low lcd bits exist", rv, 6'b000111);
    wr(2'd3, 6'h00);
  endtask

  task automatic t_periph();
    wr(2'd1, 6'h00); wr(2'd0, 6'b000001);
    ext_in = 6'b0;
    per_oe = 6'b000011; per_out = 6'b000010;
    @(negedge clk);
    check("R7 periph enables drive", pad_oe, 6'b000011);
    check("R7 periph value", pad_out & pad_oe, 6'b000010);
    settle();
    rd(2'd0, 1'b0, rv); check("R7 ordinary read sees periph", rv, 6'b000010);
    rd(2'd0, 1'b1, rv); check("R7 rmw read sees latch", rv, 6'b000001);
    wr(2'd1, 6'h3F);
    check("R7 periph over direction", pad_out & pad_oe, 6'b000010 | (6'b000001 & 6'b110100));
    per_oe = '0; per_out = '0;
  endtask

  task automatic t_pullup();
    wr(2'd2, 6'h3F);
    rd(2'd2, 1'b0, rv); check("R12 pull bit3 ignored", rv, 6'b110111);
    wr(2'd1, 6'h00);
    check("R11 pull on inputs", pad_pu, 6'b110111);
    wr(2'd1, 6'h3F); wr(2'd0, 6'h00);
    check("R11 pull off driving low", pad_pu, 6'b0);
    wr(2'd0, 6'b010001);
    check("R11 pull only on high drive", pad_pu, 6'b010001);
  endtask

  task automatic t_standby();
    wr(2'd0, 6'h3F); wr(2'd1, 6'h3F);
    @(negedge clk); standby = 1'b1; hiz_sel = 1'b0;
    @(negedge clk);
    check("R10 drive kept", pad_oe, 6'b110111);
    check("R10 value kept", pad_out & pad_oe, 6'b110111);
    hiz_sel = 1'b1;
    @(negedge clk);
    check("R9 forced high-Z", pad_oe, 6'b0);
    check("R9 pull released", pad_pu, 6'b0);
    wr(2'd1, 6'h00);
    ext_in = 6'h3F; settle();
    rd(2'd0, 1'b0, rv); check("R9 input clamped", rv, 6'b0);
    standby = 1'b0; hiz_sel = 1'b0; settle();
    rd(2'd0, 1'b0, rv); check("R9 input back after standby", rv, 6'b110111);
    check("R12 pin3 never drives", {5'b0, pad_oe[3]}, 6'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_output();
    t_input();
    t_periph();
    t_pullup();
    t_standby();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule